// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

The block is a watchdog counter for a small controller. It counts enable ticks from one of three sources: a free-running RC tick, a 32 kHz real-time tick, or the instruction clock. The instruction clock is the system-clock enable divided by four inside the block. Every tick advances a fixed 8-bit divide-by-256 stage. The carry of that stage drives a 7-bit prescaler. A control byte picks one of eight prescaler taps, so the time-out is 256 × 2^k ticks.

Software must restart the count before it expires. Depending on a configuration input, one clear command is enough, or two distinct clear commands must both arrive. Entering halt also restarts the count, and so does the asynchronous external reset.

An expiry in normal operation gives a one-cycle chip-reset request and raises a time-out flag. An expiry while halted gives a one-cycle warm-reset request instead.

Top module: `wdog_timer`

## Requirements
- R1: After the active-low asynchronous reset, the control byte reads 0x07, and `to_flag_o`, `chip_rst_o` and `warm_rst_o` are 0.
- R2: `src_sel_i` chooses the tick source: 0 selects `rc_tick_i`, 1 selects `rtc_tick_i`, 2 selects one tick per four `sys_tick_i` pulses (the fourth, eighth, and so on since reset), and 3 selects no source. Pulses on unselected inputs do not advance the count.
- R3: With control bits [2:0] = 0, a request pulse appears in the cycle after the 256th counted tick.
- R4: Control bits [2:0] = k set the time-out to 256 × 2^k ticks, for k from 0 to 7.
- R5: Control bits [7:3] are read/write storage, returned on `reg_rdata_o`, and have no effect on the time-out.
- R6: The external reset, an accepted clear command, and the rising edge of `halt_i` each restart the time-out from zero.
- R7: With `dual_clr_i` = 0, a pulse on `clr_i` restarts the count, and `clr1_i` and `clr2_i` are ignored.
- R8: With `dual_clr_i` = 1, the count restarts only once both `clr1_i` and `clr2_i` have been seen, in the same cycle or in any order. Repeats of one type are not enough. `clr_i` is ignored. Any restart discards the remembered commands.
- R9: An expiry while `halt_i` = 0 gives `chip_rst_o` high for exactly one cycle and sets `to_flag_o`. The count then starts again from zero.
- R10: An expiry while `halt_i` = 1 gives `warm_rst_o` high for exactly one cycle, gives no `chip_rst_o`, and leaves `to_flag_o` unchanged.
- R11: With source 2 selected, counting is frozen while `halt_i` = 1.
- R12: An accepted clear in the same cycle as the final tick suppresses the request. `to_flag_o` is cleared by an accepted clear and by halt entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low external reset |
| src_sel_i | input | 2 | Tick source select |
| rc_tick_i | input | 1 | RC oscillator tick enable |
| rtc_tick_i | input | 1 | Real-time oscillator tick enable |
| sys_tick_i | input | 1 | System clock enable, divided by four internally |
| dual_clr_i | input | 1 | 1 = two-command clear option |
| clr_i | input | 1 | Single clear command pulse |
| clr1_i | input | 1 | First-type clear command pulse |
| clr2_i | input | 1 | Second-type clear command pulse |
| halt_i | input | 1 | Halt mode level |
| reg_wr_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte read data |
| to_flag_o | output | 1 | Time-out status flag |
| chip_rst_o | output | 1 | Normal-mode expiry request pulse |
| warm_rst_o | output | 1 | Halt-mode expiry request pulse |

## Verification
The colliding case is an accepted clear that lands in the same clock cycle as the tick that would expire the count. The bench runs exactly 255 ticks. It then raises the tick and `clr_i` together at one falling edge and checks that no request appears on the next sample and that the flag drops. It then counts another full 256 ticks, so the count is shown to have restarted from zero rather than wrapped. The same collision is repeated with `clr1_i` and `clr2_i` raised together in the two-command mode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SRC_RC    = 2'd0,
    SRC_RTC   = 2'd1,
    SRC_INSTR = 2'd2,
    SRC_NONE  = 2'd3
  } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter int unsigned IDIV_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  wdog_pkg::wdog_src_e  src_i,
  input  logic                 rc_tick_i,
  input  logic                 rtc_tick_i,
  input  logic                 sys_tick_i,
  input  logic                 halt_i,
  output logic                 tick_o
);
  logic [IDIV_W-1:0] idiv_q;
  logic              instr_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         idiv_q <= '0;
    else if (sys_tick_i) idiv_q <= idiv_q + 1'b1;
  end

  assign instr_tick = sys_tick_i && (&idiv_q);

  always_comb begin
    unique case (src_i)
      wdog_pkg::SRC_RC:    tick_o = rc_tick_i;
      wdog_pkg::SRC_RTC:   tick_o = rtc_tick_i;
      wdog_pkg::SRC_INSTR: tick_o = instr_tick && !halt_i; // instr clock stops in halt
      default:             tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdog_clr_ctrl.sv
module wdog_clr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dual_i,
  input  logic clr_i,
  input  logic clr1_i,
  input  logic clr2_i,
  input  logic flush_i,
  output logic cmd_clr_o
);
  logic pend1_q, pend2_q;
  logic seen1, seen2;

  assign seen1     = pend1_q || clr1_i;
  assign seen2     = pend2_q || clr2_i;
  assign cmd_clr_o = dual_i ? (seen1 && seen2) : clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
    end else if (cmd_clr_o || flush_i || !dual_i) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
    end else begin
      pend1_q <= seen1;
      pend2_q <= seen2;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned SEL_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);
  localparam int unsigned NTAP = PRE_W + 1;

  logic [BASE_W-1:0] base_q;
  logic [PRE_W-1:0]  pre_q;
  logic [NTAP-1:0]   tap;
  logic              base_full;

  // tap[g]: low g prescaler bits all set
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    if (g == 0) begin : g_t0
      assign tap[g] = 1'b1;
    end else begin : g_tn
      assign tap[g] = &pre_q[g-1:0];
    end
  end

  assign base_full = &base_q;
  assign ovf_o     = tick_i && base_full && tap[sel_i] && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (clr_i) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (tick_i) begin
      base_q <= base_q + 1'b1;
      if (ovf_o)          pre_q <= '0;
      else if (base_full) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned BASE_W  = 8,
  parameter int unsigned PRE_W   = 7,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned REG_W   = 8,
  parameter logic [7:0]  CTL_RST = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             rc_tick_i,
  input  logic             rtc_tick_i,
  input  logic             sys_tick_i,
  input  logic             dual_clr_i,
  input  logic             clr_i,
  input  logic             clr1_i,
  input  logic             clr2_i,
  input  logic             halt_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             to_flag_o,
  output logic             chip_rst_o,
  output logic             warm_rst_o
);
  logic [REG_W-1:0] ctl_q;
  logic halt_q, halt_entry;
  logic tick, cmd_clr, cnt_clr, ovf;
  logic chip_q, warm_q, to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= REG_W'(CTL_RST);
    else if (reg_wr_i) ctl_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= halt_i;
  end

  assign halt_entry = halt_i && !halt_q;
  assign cnt_clr    = cmd_clr || halt_entry;

  wdog_tick_sel #(.IDIV_W(2)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (wdog_pkg::wdog_src_e'(src_sel_i)),
    .rc_tick_i  (rc_tick_i),
    .rtc_tick_i (rtc_tick_i),
    .sys_tick_i (sys_tick_i),
    .halt_i     (halt_i),
    .tick_o     (tick)
  );

  wdog_clr_ctrl u_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dual_i    (dual_clr_i),
    .clr_i     (clr_i),
    .clr1_i    (clr1_i),
    .clr2_i    (clr2_i),
    .flush_i   (halt_entry),
    .cmd_clr_o (cmd_clr)
  );

  wdog_counter #(.BASE_W(BASE_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (tick),
    .sel_i  (ctl_q[SEL_W-1:0]),
    .ovf_o  (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= 1'b0;
      warm_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      chip_q <= ovf && !halt_i;
      warm_q <= ovf && halt_i;
      if (cnt_clr)              to_q <= 1'b0;
      else if (ovf && !halt_i)  to_q <= 1'b1;
    end
  end

  assign reg_rdata_o = ctl_q;
  assign to_flag_o   = to_q;
  assign chip_rst_o  = chip_q;
  assign warm_rst_o  = warm_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] src_sel_i,
  input logic       dual_clr_i,
  input logic       clr_i,
  input logic       halt_i,
  input logic       to_flag_o,
  input logic       chip_rst_o,
  input logic       warm_rst_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chip_rst_o && warm_rst_o)); // R10
  AST_CHIP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |=> !chip_rst_o); // R9
  AST_WARM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |=> !warm_rst_o); // R10
  AST_CHIP_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> !$past(halt_i)); // R9
  AST_WARM_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> $past(halt_i)); // R10
  AST_FLAG_ON_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> to_flag_o); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !dual_clr_i) |=> !(chip_rst_o || warm_rst_o)); // R12
  AST_HALT_ENTRY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_i) |=> !to_flag_o); // R12
  AST_INSTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> ($past(src_sel_i) != 2'd2)); // R11
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_sel_i  (src_sel_i),
  .dual_clr_i (dual_clr_i),
  .clr_i      (clr_i),
  .halt_i     (halt_i),
  .to_flag_o  (to_flag_o),
  .chip_rst_o (chip_rst_o),
  .warm_rst_o (warm_rst_o)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic       rc_tick = 1'b0, rtc_tick = 1'b0, sys_tick = 1'b0;
  logic       dual = 1'b0, clr = 1'b0, clr1 = 1'b0, clr2 = 1'b0;
  logic       halt = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       to_flag, chip_rst, warm_rst;
  int         checks = 0, fails = 0;

  always #2 clk = ~clk;

  wdog_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel),
    .rc_tick_i(rc_tick), .rtc_tick_i(rtc_tick), .sys_tick_i(sys_tick),
    .dual_clr_i(dual), .clr_i(clr), .clr1_i(clr1), .clr2_i(clr2),
    .halt_i(halt), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .to_flag_o(to_flag),
    .chip_rst_o(chip_rst), .warm_rst_o(warm_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // which: 0 rc, 1 rtc, 2 sys
  task automatic run_ticks(input int n, input int which,
                           output int nchip, output int nwarm, output int first);
    nchip = 0; nwarm = 0; first = 0;
    @(negedge clk);
    case (which)
      0: rc_tick = 1'b1;
      1: rtc_tick = 1'b1;
      default: sys_tick = 1'b1;
    endcase
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == n) begin rc_tick = 1'b0; rtc_tick = 1'b0; sys_tick = 1'b0; end
      if (chip_rst) begin nchip++; if (first == 0) first = i; end
      if (warm_rst) begin nwarm++; if (first == 0) first = i; end
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // which: 0 clr, 1 clr1, 2 clr2, 3 clr1+clr2
  task automatic pulse_clr(input int which);
    @(negedge clk);
    case (which)
      0: clr = 1'b1;
      1: clr1 = 1'b1;
      2: clr2 = 1'b1;
      default: begin clr1 = 1'b1; clr2 = 1'b1; end
    endcase
    @(negedge clk); clr = 1'b0; clr1 = 1'b0; clr2 = 1'b0;
  endtask

  task automatic expect_first(input int n, input int which, input int exp_first,
                              input bit warm_exp, input string req);
    int nc, nw, f;
    run_ticks(n, which, nc, nw, f);
    chk(f == exp_first, req, f, exp_first);
    if (exp_first != 0) chk(warm_exp ? (nw == 1 && nc == 0) : (nc == 1 && nw == 0),
                            req, warm_exp ? nw : nc, 1);
  endtask

  task automatic t_reset();
    chk(reg_rdata == 8'h07, "R1 ctl", reg_rdata, 8'h07);
    chk({to_flag, chip_rst, warm_rst} == 3'b000, "R1 outs",
        {to_flag, chip_rst, warm_rst}, 0);
  endtask

  task automatic t_base();
    wr_reg(8'h00); pulse_clr(0);
    expect_first(256, 0, 256, 1'b0, "R3 base 256");
    chk(to_flag == 1'b1, "R9 flag set", to_flag, 1);
    expect_first(256, 0, 256, 1'b0, "R9 wrap restart");
  endtask

  task automatic t_ratio();
    wr_reg(8'h01); pulse_clr(0);
    expect_first(512, 0, 512, 1'b0, "R4 ratio 1:2");
    wr_reg(8'h02); pulse_clr(0);
    expect_first(1024, 0, 1024, 1'b0, "R4 ratio 1:4");
    wr_reg(8'h07); pulse_clr(0);
    expect_first(32768, 0, 32768, 1'b0, "R4 ratio 1:128");
  endtask

  task automatic t_user();
    wr_reg(8'hA8);
    chk(reg_rdata == 8'hA8, "R5 readback", reg_rdata, 8'hA8);
    pulse_clr(0);
    expect_first(256, 0, 256, 1'b0, "R5 user bits no timing effect");
    wr_reg(8'h00);
  endtask

  task automatic t_src();
    src_sel = 2'd1; pulse_clr(0);
    expect_first(300, 0, 0, 1'b0, "R2 rc ignored when rtc selected");
    pulse_clr(0);
    expect_first(256, 1, 256, 1'b0, "R2 rtc source");
    src_sel = 2'd3; pulse_clr(0);
    expect_first(300, 0, 0, 1'b0, "R2 none selected rc");
    expect_first(300, 1, 0, 1'b0, "R2 none selected rtc");
    src_sel = 2'd2; pulse_clr(0);
    expect_first(1024, 2, 1024, 1'b0, "R2 instr clock sys/4");
    src_sel = 2'd0;
  endtask

  task automatic t_halt();
    int nc, nw, f;
    pulse_clr(0);
    expect_first(256, 0, 256, 1'b0, "R9 flag prep");
    run_ticks(100, 0, nc, nw, f);
    @(negedge clk); halt = 1'b1;
    @(negedge clk);
    chk(to_flag == 1'b0, "R12 halt entry clears flag", to_flag, 0);
    expect_first(256, 0, 256, 1'b1, "R6 R10 halt entry restart warm");
    chk(to_flag == 1'b0, "R10 flag unchanged", to_flag, 0);
    src_sel = 2'd2;
    expect_first(2100, 2, 0, 1'b0, "R11 instr frozen in halt");
    @(negedge clk); halt = 1'b0; src_sel = 2'd0;
  endtask

  task automatic t_ext_reset();
    int nc, nw, f;
    pulse_clr(0);
    run_ticks(200, 0, nc, nw, f);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(reg_rdata == 8'h07, "R6 R1 reset ctl", reg_rdata, 8'h07);
    wr_reg(8'h00);
    expect_first(256, 0, 256, 1'b0, "R6 ext reset restart");
  endtask

  task automatic t_single();
    int nc, nw, f;
    dual = 1'b0; pulse_clr(0);
    run_ticks(200, 0, nc, nw, f);
    pulse_clr(1); pulse_clr(2);
    expect_first(56, 0, 56, 1'b0, "R7 clr1/clr2 ignored");
    run_ticks(100, 0, nc, nw, f);
    pulse_clr(0);
    expect_first(256, 0, 256, 1'b0, "R7 clr restarts");
  endtask

  task automatic t_dual();
    int nc, nw, f;
    dual = 1'b0; pulse_clr(0); dual = 1'b1;
    run_ticks(200, 0, nc, nw, f);
    pulse_clr(1); pulse_clr(1);
    expect_first(56, 0, 56, 1'b0, "R8 repeated clr1 not enough");
    run_ticks(100, 0, nc, nw, f);
    pulse_clr(0);
    expect_first(156, 0, 156, 1'b0, "R8 clr ignored in dual");
    run_ticks(100, 0, nc, nw, f);
    pulse_clr(2);
    expect_first(256, 0, 256, 1'b0, "R8 clr1 then clr2 restarts");
    run_ticks(100, 0, nc, nw, f);
    pulse_clr(2);
    expect_first(156, 0, 156, 1'b0, "R8 pending dropped after restart");
    dual = 1'b0;
  endtask

  task automatic t_coincide();
    int nc, nw, f;
    pulse_clr(0);
    expect_first(256, 0, 256, 1'b0, "R12 flag prep");
    run_ticks(255, 0, nc, nw, f);
    @(negedge clk); rc_tick = 1'b1; clr = 1'b1;
    @(negedge clk); rc_tick = 1'b0; clr = 1'b0;
    chk(chip_rst == 1'b0, "R12 clear beats final tick", chip_rst, 0);
    chk(to_flag == 1'b0, "R12 clear drops flag", to_flag, 0);
    expect_first(256, 0, 256, 1'b0, "R12 restarted from zero");
    dual = 1'b1;
    run_ticks(255, 0, nc, nw, f);
    @(negedge clk); rc_tick = 1'b1; clr1 = 1'b1; clr2 = 1'b1;
    @(negedge clk); rc_tick = 1'b0; clr1 = 1'b0; clr2 = 1'b0;
    chk(chip_rst == 1'b0, "R8 R12 dual same-cycle clear", chip_rst, 0);
    expect_first(256, 0, 256, 1'b0, "R8 dual restart from zero");
    dual = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_ratio();
    t_user();
    t_src();
    t_halt();
    t_ext_reset();
    t_single();
    t_dual();
    t_coincide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule